// File: doc/BRIEF.md
# Instruction Cache with Profiling Counters

This block is a direct-mapped, read-only instruction cache placed between a processor fetch port and a slower flash read port. A fetch that finds its line resident is answered combinationally in the cycle it is presented. A fetch that misses asks flash for the whole 16-byte line, waits as many cycles as flash takes, forwards the requested word and keeps the line for later fetches.

Two conditions empty the cache. Clearing the enable bit empties it, and while the cache is disabled every fetch passes straight through to flash. The cache is also emptied, and held empty, whenever the flash controller is in write or erase mode. In that mode lookups always miss and nothing is refilled.

When profiling is enabled, two 32-bit counters record hits and misses. Software reads them through a small register port and clears them by writing zero. Both counters stop at all ones.

Top module: `icache_prof`

## Requirements
- R1: A fetch whose line is valid and whose tag matches, with the cache enabled and the hold input low, asserts fetchReady with the correct word in the same cycle as fetchReq (zero wait states).
- R2: A fetch that misses raises flashReq from the next cycle, with flashLineAddr equal to the fetch address bits [31:4]. flashReq stays high until flashValid. fetchReady is asserted in the flashValid cycle with the word chosen by address bits [3:2] (word 0 in flashLine bits [31:0]). A miss therefore takes as many cycles as flash latency.
- R3: The cache holds 128 lines of 16 bytes (2048 bytes). It is indexed by address bits [10:4] and tagged by bits [31:11]. A fetch to an address that maps to the same index with another tag evicts the resident line.
- R4: While the enable bit is 0, every fetch goes to flash, no line is stored and the counters do not change. Clearing the enable bit invalidates every line, so after re-enabling, the first fetch of a previously resident line misses.
- R5: While flashModeHold is 1, all lines are invalidated and kept invalid, every lookup misses and no refill is stored. After release, previously resident lines miss.
- R6: With the cache enabled and profiling enabled, the hit counter increments by one per hit. It does not change when profiling is off.
- R7: With the cache enabled and profiling enabled, the miss counter increments by one per miss, including misses forced by the hold input.
- R8: A register write loads the selected counter with regWdata, so writing zero clears it.
- R9: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF on further events.
- R10: regSel selects 0 = configuration, 1 = hit counter, 2 = miss counter. In the configuration register, bit 0 is cache enable and bit 8 is profiling enable, and all other bits read 0. All three registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchReq | input | 1 | Fetch request, held with a stable address until fetchReady |
| fetchWordAddr | input | 30 | Word address of the fetch (byte address bits [31:2]) |
| fetchReady | output | 1 | Fetch answered this cycle |
| fetchData | output | 32 | Fetched instruction word, valid with fetchReady |
| flashReq | output | 1 | Line read request to flash |
| flashLineAddr | output | 28 | Line address for flash (byte address bits [31:4]) |
| flashValid | input | 1 | Flash line data valid this cycle |
| flashLine | input | 128 | Line data from flash, word 0 in the low bits |
| flashModeHold | input | 1 | High while flash write or erase mode is active |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 config, 1 hits, 2 misses |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regSel |

## Verification
The bench builds the cache with its default geometry: 32-bit addresses, 16-byte lines and 128 lines. Addresses 2048 bytes apart therefore collide on one index, which brings eviction within reach of a short table. The line at index 127 also exercises the top of the index range. The flash model answers after three cycles, so a miss is easy to tell from a hit by counting cycles. Saturation is reached by loading a counter one below all ones through the register port rather than by running billions of fetches.

// File: rtl/icache_pkg.sv
package icache_pkg;

  localparam int REG_W        = 32;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_PROF_BIT = 8;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_HIT  = 2'd1;
  localparam logic [1:0] SEL_MISS = 2'd2;

  typedef struct packed {
    logic fill;      // store the returning flash line
    logic flush;     // clear every valid bit
    logic incHit;    // bump the hit counter
    logic incMiss;   // bump the miss counter
    logic fwdFlash;  // answer from the flash line instead of the array
  } cacheStrobe_t;

endpackage

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fetchReq,
  input  logic         tagHit,
  input  logic         cfgEn,
  input  logic         cfgProf,
  input  logic         flashValid,
  input  logic         holdInv,
  output cacheStrobe_t strobe,
  output logic         fetchReady,
  output logic         flashReq
);

  typedef enum logic {ST_IDLE, ST_FILL} ctrlState_t;
  ctrlState_t state, stateNext;

  logic lookup, lookupHit, fillDone;

  always_comb begin
    lookup    = (state == ST_IDLE) && fetchReq;
    lookupHit = lookup && cfgEn && !holdInv && tagHit;
    fillDone  = (state == ST_FILL) && flashValid;

    strobe.flush    = !cfgEn || holdInv;
    strobe.fill     = fillDone && cfgEn && !holdInv;
    strobe.incHit   = lookupHit && cfgProf;
    strobe.incMiss  = lookup && !lookupHit && cfgEn && cfgProf;
    strobe.fwdFlash = (state == ST_FILL);

    fetchReady = lookupHit || fillDone;
    flashReq   = (state == ST_FILL);

    stateNext = state;
    if (lookup && !lookupHit) stateNext = ST_FILL;
    else if (fillDone)        stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cacheStrobe_t            strobe,
  input  logic [ADDR_W-1:2]       fetchWordAddr,
  input  logic [LINE_BYTES*8-1:0] flashLine,
  input  logic                    regWe,
  input  logic [1:0]              regSel,
  input  logic [REG_W-1:0]        regWdata,
  output logic                    tagHit,
  output logic [31:0]             fetchData,
  output logic                    cfgEn,
  output logic                    cfgProf,
  output logic [REG_W-1:0]        regRdata
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSEL_W = OFF_W - 2;
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;

  logic [TAG_W-1:0]  tagMem  [NUM_LINES];
  logic [LINE_W-1:0] dataMem [NUM_LINES];
  logic [NUM_LINES-1:0] validVec;
  logic [REG_W-1:0] hitCnt, missCnt;

  logic [WSEL_W-1:0] wordSel;
  logic [IDX_W-1:0]  lineIdx;
  logic [TAG_W-1:0]  lineTag;
  logic [LINE_W-1:0] srcLine;

  assign wordSel = fetchWordAddr[OFF_W-1:2];
  assign lineIdx = fetchWordAddr[OFF_W+IDX_W-1:OFF_W];
  assign lineTag = fetchWordAddr[ADDR_W-1:OFF_W+IDX_W];

  assign tagHit    = validVec[lineIdx] && (tagMem[lineIdx] == lineTag);
  assign srcLine   = strobe.fwdFlash ? flashLine : dataMem[lineIdx];
  assign fetchData = srcLine[wordSel*32 +: 32];

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagMem[lineIdx]  <= lineTag;
      dataMem[lineIdx] <= flashLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             validVec <= '0;
    else if (strobe.flush) validVec <= '0;
    else if (strobe.fill)  validVec[lineIdx] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      cfgProf <= 1'b0;
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      if (regWe && regSel == SEL_CFG) begin
        cfgEn   <= regWdata[CFG_EN_BIT];
        cfgProf <= regWdata[CFG_PROF_BIT];
      end
      if (regWe && regSel == SEL_HIT)      hitCnt <= regWdata;
      else if (strobe.incHit && ~&hitCnt)  hitCnt <= hitCnt + 1'b1;
      if (regWe && regSel == SEL_MISS)     missCnt <= regWdata;
      else if (strobe.incMiss && ~&missCnt) missCnt <= missCnt + 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CFG: begin
        regRdata[CFG_EN_BIT]   = cfgEn;
        regRdata[CFG_PROF_BIT] = cfgProf;
      end
      SEL_HIT:  regRdata = hitCnt;
      SEL_MISS: regRdata = missCnt;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/icache_prof.sv
module icache_prof
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 128
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 fetchReq,
  input  logic [ADDR_W-1:2]                    fetchWordAddr,
  output logic                                 fetchReady,
  output logic [31:0]                          fetchData,
  output logic                                 flashReq,
  output logic [ADDR_W-1:$clog2(LINE_BYTES)]   flashLineAddr,
  input  logic                                 flashValid,
  input  logic [LINE_BYTES*8-1:0]              flashLine,
  input  logic                                 flashModeHold,
  input  logic                                 regWe,
  input  logic [1:0]                           regSel,
  input  logic [REG_W-1:0]                     regWdata,
  output logic [REG_W-1:0]                     regRdata
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  cacheStrobe_t strobe;
  logic tagHit, cfgEn, cfgProf;

  assign flashLineAddr = fetchWordAddr[ADDR_W-1:OFF_W];

  icache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .tagHit(tagHit),
    .cfgEn(cfgEn), .cfgProf(cfgProf), .flashValid(flashValid),
    .holdInv(flashModeHold), .strobe(strobe), .fetchReady(fetchReady),
    .flashReq(flashReq)
  );

  icache_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchWordAddr(fetchWordAddr),
    .flashLine(flashLine), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .tagHit(tagHit), .fetchData(fetchData), .cfgEn(cfgEn), .cfgProf(cfgProf),
    .regRdata(regRdata)
  );

endmodule

// File: rtl/icache_prof_chk.sv
module icache_prof_chk
  import icache_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             fetchReq,
  input logic             fetchReady,
  input logic             flashReq,
  input logic             flashValid,
  input logic             regWe,
  input logic [1:0]       regSel,
  input logic [REG_W-1:0] regRdata
);

  // R1: an answer is only given to a pending request
  p_ready_needs_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    fetchReady |-> fetchReq);

  // R2: a flash request is held until flash answers
  p_fill_waits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && !flashValid) |=> flashReq);

  // R2: no answer while the line is still outstanding
  p_no_early_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && !flashValid) |-> !fetchReady);

  // R6: hit counter moves by at most one per cycle when not written
  p_hit_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_HIT && $past(regSel) == SEL_HIT && !$past(regWe))
      |-> (regRdata == $past(regRdata) || regRdata == $past(regRdata) + 32'd1));

  // R7: miss counter moves by at most one per cycle when not written
  p_miss_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_MISS && $past(regSel) == SEL_MISS && !$past(regWe))
      |-> (regRdata == $past(regRdata) || regRdata == $past(regRdata) + 32'd1));

  // R9: a saturated counter stays saturated
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regSel != SEL_CFG && regSel == $past(regSel) && !$past(regWe) && &$past(regRdata))
      |-> &regRdata);

endmodule

bind icache_prof icache_prof_chk uChk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchReady(fetchReady),
  .flashReq(flashReq), .flashValid(flashValid), .regWe(regWe),
  .regSel(regSel), .regRdata(regRdata)
);

// File: tb/icache_prof_bench.sv
module icache_prof_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FLASH_LAT  = 3;
  localparam logic [31:0] DATA_KEY = 32'h5A5A_5A5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchReq = 1'b0;
  logic [31:2] fetchWordAddr = '0;
  logic fetchReady;
  logic [31:0] fetchData;
  logic flashReq;
  logic [31:4] flashLineAddr;
  logic flashValid = 1'b0;
  logic [127:0] flashLine = '0;
  logic flashModeHold = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_prof u_icache_prof (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchWordAddr(fetchWordAddr),
    .fetchReady(fetchReady), .fetchData(fetchData), .flashReq(flashReq),
    .flashLineAddr(flashLineAddr), .flashValid(flashValid), .flashLine(flashLine),
    .flashModeHold(flashModeHold), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ DATA_KEY;
  endfunction

  // flash model: fixed latency, answers with a whole line
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      flashValid = 1'b0;
      if (flashReq) begin
        cnt++;
        if (cnt == FLASH_LAT) begin
          cnt = 0;
          flashValid = 1'b1;
          for (int w = 0; w < 4; w++)
            flashLine[w*32 +: 32] = memWord({flashLineAddr, 4'b0} + 32'(w*4));
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doFetch(input logic [31:0] a, output logic [31:0] d, output int cyc);
    @(negedge clk);
    fetchReq = 1'b1;
    fetchWordAddr = a[31:2];
    cyc = 0;
    #1;
    while (!fetchReady) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    d = fetchData;
    @(negedge clk);
    fetchReq = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    regSel = sel;
    #1;
    v = regRdata;
  endtask

  // fetch and compare data plus hit (0 cycles) or miss (FLASH_LAT cycles)
  task automatic fetchExpect(input string req, input logic [31:0] a, input bit expHit);
    logic [31:0] d;
    int cyc;
    doFetch(a, d, cyc);
    check(req, d, memWord(a));
    check(req, 32'(cyc), expHit ? 32'd0 : 32'(FLASH_LAT));
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        expHit;
  } vec_t;

  // R1 R2 R3: hits, misses, eviction at index 0 and 1, top index 127
  localparam vec_t VECS [13] = '{
    '{32'h0000_0000, 1'b0}, '{32'h0000_0004, 1'b1}, '{32'h0000_000C, 1'b1},
    '{32'h0000_0010, 1'b0}, '{32'h0000_0800, 1'b0}, '{32'h0000_0000, 1'b0},
    '{32'h0000_0808, 1'b0}, '{32'h0000_0014, 1'b1}, '{32'h0000_07F0, 1'b0},
    '{32'h0000_07FC, 1'b1}, '{32'h1000_0010, 1'b0}, '{32'h0000_0018, 1'b0},
    '{32'h0000_0808, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] h0;
    int expHits = 0;
    int expMiss = 0;

    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check("R10 reset fetchReady", {31'b0, fetchReady}, 32'd0);
    check("R10 reset flashReq", {31'b0, flashReq}, 32'd0);
    regRead(2'd0, v); check("R10 reset config", v, 32'd0);
    rstN = 1'b1;
    regRead(2'd1, v); check("R10 reset hits", v, 32'd0);
    regRead(2'd2, v); check("R10 reset misses", v, 32'd0);

    // R4 disabled: pass-through, no fill, no counting even with profiling on
    regWrite(2'd0, 32'h0000_0100);
    fetchExpect("R4 disabled fetch", 32'h0000_0020, 1'b0);
    fetchExpect("R4 disabled refetch", 32'h0000_0020, 1'b0);
    regRead(2'd1, v); check("R4 disabled hits", v, 32'd0);
    regRead(2'd2, v); check("R4 disabled misses", v, 32'd0);

    // R10 configuration bits 0 and 8 only
    regWrite(2'd0, 32'hFFFF_FFFF);
    regRead(2'd0, v); check("R10 config readback", v, 32'h0000_0101);

    // vector table
    for (int i = 0; i < 13; i++) begin
      fetchExpect("R1 R2 R3 table", VECS[i].addr, VECS[i].expHit);
      if (VECS[i].expHit) expHits++; else expMiss++;
    end
    regRead(2'd1, v); check("R6 hit count", v, 32'(expHits));
    regRead(2'd2, v); check("R7 miss count", v, 32'(expMiss));

    // R5 hold: forced misses, no refill, invalid after release
    @(negedge clk); flashModeHold = 1'b1;
    fetchExpect("R5 held fetch", 32'h0000_0808, 1'b0);
    fetchExpect("R5 held refetch", 32'h0000_0808, 1'b0);
    @(negedge clk); flashModeHold = 1'b0;
    fetchExpect("R5 after release", 32'h0000_0808, 1'b0);
    fetchExpect("R5 refilled", 32'h0000_0808, 1'b1);
    regRead(2'd2, v); check("R7 hold misses counted", v, 32'(expMiss + 3));

    // R4 disable clears contents
    regWrite(2'd0, 32'h0000_0100);
    regWrite(2'd0, 32'h0000_0101);
    fetchExpect("R4 cleared by disable", 32'h0000_0808, 1'b0);

    // R6 profiling off: hit not counted
    regWrite(2'd0, 32'h0000_0001);
    regRead(2'd1, h0);
    fetchExpect("R6 hit profiling off", 32'h0000_0808, 1'b1);
    regRead(2'd1, v); check("R6 no count when profiling off", v, h0);
    regWrite(2'd0, 32'h0000_0101);

    // R8 write zero clears
    regWrite(2'd1, 32'd0);
    regRead(2'd1, v); check("R8 hits cleared", v, 32'd0);
    regWrite(2'd2, 32'd0);
    regRead(2'd2, v); check("R8 misses cleared", v, 32'd0);

    // R9 saturation
    regWrite(2'd1, 32'hFFFF_FFFE);
    fetchExpect("R9 hit one", 32'h0000_0808, 1'b1);
    fetchExpect("R9 hit two", 32'h0000_080C, 1'b1);
    regRead(2'd1, v); check("R9 hit counter saturates", v, 32'hFFFF_FFFF);
    regWrite(2'd2, 32'hFFFF_FFFF);
    fetchExpect("R9 miss", 32'h0000_0A00, 1'b0);
    regRead(2'd2, v); check("R9 miss counter saturates", v, 32'hFFFF_FFFF);

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule